// File: doc/BRIEF.md
# Branch Confidence Fetch Gating Controller

This block rates every predicted branch at fetch time as high or low confidence and holds instruction fetch back while too many low-confidence branches remain unresolved. Its purpose is to cut the wrong-path work a front end does behind branches that are likely to be mispredicted. The rating combines two estimators. The first is a table of small per-PC counters. The second is a distance rule that distrusts the branches fetched just after a mispredict.

The table has two modes. In streak mode each counter records how many correct predictions its entry has seen in a row, and a mispredict clears it. In saturating mode each counter tracks the actual branch direction, and the counter is treated as untrustworthy while it sits in its middle, weakly biased states. A counter of unresolved low-confidence branches rises at fetch and falls at resolve. A flush clears it. A registered gate output stops fetch once the count reaches a programmable threshold.

Top module: `brconf_gate`

## Requirements
- R1: After reset every table counter is 0, the distance counter is saturated (at 4), the outstanding count is 0, and `fetch_gate` is 0.
- R2: In streak mode (`cfg_mode`=0) an entry is high confidence when its counter is at least `cfg_streak_n`. A correct resolve increments the counter, saturating at 15. A mispredict resolve clears it to 0.
- R3: The distance counter drops to 0 on a mispredict resolve and rises by one per fetched branch up to 4. A branch fetched while it is below 4 is rated low, so the first four branches after a mispredict are always low.
- R4: The outstanding count rises by one on fetch of a low-confidence branch and falls by one on resolve of a branch flagged `rslv_low`. It never goes below 0 and saturates at 15. An increment and a decrement in the same cycle cancel.
- R5: `flush` clears the outstanding count, and `fetch_gate` is 0 in the cycle after the flush.
- R6: `fetch_gate` is a register. It is 1 in a cycle exactly when, one cycle earlier, the count was at least a nonzero `cfg_thresh` and no flush was present. A `cfg_thresh` of 0 never gates.
- R7: In saturating mode (`cfg_mode`=1) a resolve with `rslv_taken`=1 increments the entry and one with `rslv_taken`=0 decrements it, saturating at 0 and 15. The entry is high confidence only when its two top bits are equal, which means the values 0–3 or 12–15.
- R8: A fetch and a resolve to the same index in the same cycle rate the fetch with the counter value from before the update.
- R9: `fetch_conf` reflects the current fetch in the same cycle and is 0 whenever `fetch_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 1 | 0 = streak estimator, 1 = saturating direction estimator |
| cfg_streak_n | input | 4 | Correct-streak length needed for high confidence |
| cfg_thresh | input | 4 | Outstanding low-confidence count that gates fetch (0 disables) |
| fetch_vld | input | 1 | A predicted branch is fetched this cycle |
| fetch_idx | input | 6 | Low PC bits of the fetched branch |
| rslv_vld | input | 1 | A branch resolves this cycle |
| rslv_idx | input | 6 | Low PC bits of the resolving branch |
| rslv_ok | input | 1 | 1 = prediction was correct, 0 = mispredict |
| rslv_taken | input | 1 | Actual direction of the resolving branch |
| rslv_low | input | 1 | The resolving branch had been rated low confidence |
| flush | input | 1 | Pipeline flush, drops all outstanding branches |
| fetch_conf | output | 1 | 1 = current fetched branch is high confidence |
| fetch_gate | output | 1 | 1 = stall instruction fetch |

## Verification
A corrupted table entry appears at `fetch_conf` on the next fetch of that index. A distance counter stuck at the wrong value shows up as a wrong rating within the four fetches that follow a mispredict. An error in the outstanding count reaches the ports only through `fetch_gate`, one cycle after the count crosses the threshold. For that reason the count is steered to sit exactly at, below and above the threshold, including after extra resolves at zero and after overflow past 15.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
    typedef enum logic {
        MODE_STREAK = 1'b0,
        MODE_SAT    = 1'b1
    } conf_mode_e;
endpackage

// File: rtl/bcg_conf_table.sv
module bcg_conf_table
    import bcg_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  conf_mode_e       mode,
    input  logic [CNT_W-1:0] streak_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_high,
    input  logic             wr_vld,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_ok,
    input  logic             wr_taken
);
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] tab_q [DEPTH];
    logic [CNT_W-1:0] tab_d [DEPTH];
    logic [CNT_W-1:0] rd_cnt;
    logic [CNT_W-1:0] wr_cnt;

    // read uses the registered value: same-cycle update is not bypassed
    always_comb begin
        rd_cnt = tab_q[rd_idx];
        if (mode == MODE_STREAK) begin
            rd_high = (rd_cnt >= streak_n);
        end else begin
            rd_high = (rd_cnt[CNT_W-1] == rd_cnt[CNT_W-2]);
        end
    end

    always_comb begin
        tab_d  = tab_q;
        wr_cnt = tab_q[wr_idx];
        if (wr_vld) begin
            if (mode == MODE_STREAK) begin
                if (!wr_ok) begin
                    tab_d[wr_idx] = '0;
                end else if (wr_cnt != CMAX) begin
                    tab_d[wr_idx] = wr_cnt + CNT_W'(1);
                end
            end else begin
                if (wr_taken && wr_cnt != CMAX) begin
                    tab_d[wr_idx] = wr_cnt + CNT_W'(1);
                end else if (!wr_taken && wr_cnt != '0) begin
                    tab_d[wr_idx] = wr_cnt - CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tab_q[i] <= '0;
            end
        end else begin
            tab_q <= tab_d;
        end
    end

    // R2: a mispredict in streak mode wipes the streak
    a_r2_miss_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld && !wr_ok && mode == MODE_STREAK) |=> (tab_q[$past(wr_idx)] == '0));

    // R7: taken outcome below the ceiling moves the entry up by one
    a_r7_sat_up: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld && wr_taken && mode == MODE_SAT && tab_q[wr_idx] != CMAX)
        |=> (tab_q[$past(wr_idx)] == $past(tab_q[wr_idx]) + CNT_W'(1)));
endmodule

// File: rtl/bcg_distance.sv
module bcg_distance #(
    parameter int DIST_MAX = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fetch_vld,
    input  logic miss,
    output logic dist_ok
);
    localparam int DW = $clog2(DIST_MAX + 1);
    localparam logic [DW-1:0] DMAX = DW'(DIST_MAX);

    logic [DW-1:0] dist_d, dist_q;

    always_comb begin
        dist_d = dist_q;
        if (miss) begin
            dist_d = '0;
        end else if (fetch_vld && dist_q != DMAX) begin
            dist_d = dist_q + DW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dist_q <= DMAX;
        else        dist_q <= dist_d;
    end

    assign dist_ok = (dist_q == DMAX);

    // R3: counter is reset by a mispredict and never exceeds its ceiling
    a_r3_miss_resets: assert property (@(posedge clk) disable iff (!rst_n)
        miss |=> (dist_q == '0));
    a_r3_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        dist_q <= DMAX);
endmodule

// File: rtl/bcg_gate_ctr.sv
module bcg_gate_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    input  logic             flush,
    input  logic [CNT_W-1:0] thresh,
    output logic             gate
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             gate;
    } gate_st_t;

    gate_st_t st_d, st_q;
    logic [CNT_W:0] sum;

    always_comb begin
        sum = {1'b0, st_q.cnt} + {{CNT_W{1'b0}}, inc};
        if (dec && sum != '0) begin
            sum = sum - {{CNT_W{1'b0}}, 1'b1};
        end
        if (sum > {1'b0, CMAX}) begin
            sum = {1'b0, CMAX};
        end
        st_d.cnt  = flush ? '0 : sum[CNT_W-1:0];
        // compare on the registered count keeps the gate path short
        st_d.gate = !flush && (thresh != '0) && (st_q.cnt >= thresh);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gate = st_q.gate;

    // R5: flush empties the count and drops the gate
    a_r5_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.cnt == '0 && !st_q.gate));
    // R4: no underflow when nothing is added at zero
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0 && !inc) |=> (st_q.cnt == '0));
    // R6: gate only follows a count at or above a nonzero threshold
    a_r6_gate_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.gate) |-> ($past(thresh) != '0 && $past(st_q.cnt) >= $past(thresh)));
endmodule

// File: rtl/brconf_gate.sv
module brconf_gate
    import bcg_pkg::*;
#(
    parameter int IDX_W    = 6,
    parameter int CNT_W    = 4,
    parameter int DIST_MAX = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_mode,
    input  logic [CNT_W-1:0] cfg_streak_n,
    input  logic [CNT_W-1:0] cfg_thresh,
    input  logic             fetch_vld,
    input  logic [IDX_W-1:0] fetch_idx,
    input  logic             rslv_vld,
    input  logic [IDX_W-1:0] rslv_idx,
    input  logic             rslv_ok,
    input  logic             rslv_taken,
    input  logic             rslv_low,
    input  logic             flush,
    output logic             fetch_conf,
    output logic             fetch_gate
);
    conf_mode_e mode;
    logic       tbl_high;
    logic       dist_ok;
    logic       miss;
    logic       low_fetch;
    logic       low_rslv;

    assign mode      = conf_mode_e'(cfg_mode);
    assign miss      = rslv_vld && !rslv_ok;
    assign fetch_conf = fetch_vld && tbl_high && dist_ok;
    assign low_fetch = fetch_vld && !fetch_conf;
    assign low_rslv  = rslv_vld && rslv_low;

    bcg_conf_table #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .streak_n (cfg_streak_n),
        .rd_idx   (fetch_idx),
        .rd_high  (tbl_high),
        .wr_vld   (rslv_vld),
        .wr_idx   (rslv_idx),
        .wr_ok    (rslv_ok),
        .wr_taken (rslv_taken)
    );

    bcg_distance #(.DIST_MAX(DIST_MAX)) u_dist (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch_vld (fetch_vld),
        .miss      (miss),
        .dist_ok   (dist_ok)
    );

    bcg_gate_ctr #(.CNT_W(CNT_W)) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (low_fetch),
        .dec    (low_rslv),
        .flush  (flush),
        .thresh (cfg_thresh),
        .gate   (fetch_gate)
    );

    // R3: a branch fetched right after a mispredict is never high
    a_r3_post_miss_low: assert property (@(posedge clk) disable iff (!rst_n)
        miss |=> !fetch_conf);
endmodule

// File: tb/brconf_gate_test.sv
`timescale 1ns/1ps
module brconf_gate_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_mode = 1'b0;
    logic [3:0] cfg_streak_n = 4'd3;
    logic [3:0] cfg_thresh = 4'd2;
    logic       fetch_vld = 1'b0;
    logic [5:0] fetch_idx = '0;
    logic       rslv_vld = 1'b0;
    logic [5:0] rslv_idx = '0;
    logic       rslv_ok = 1'b0;
    logic       rslv_taken = 1'b0;
    logic       rslv_low = 1'b0;
    logic       flush = 1'b0;
    logic       fetch_conf;
    logic       fetch_gate;

    always #2 clk = ~clk;

    brconf_gate uut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_streak_n(cfg_streak_n),
        .cfg_thresh(cfg_thresh), .fetch_vld(fetch_vld), .fetch_idx(fetch_idx),
        .rslv_vld(rslv_vld), .rslv_idx(rslv_idx), .rslv_ok(rslv_ok),
        .rslv_taken(rslv_taken), .rslv_low(rslv_low), .flush(flush),
        .fetch_conf(fetch_conf), .fetch_gate(fetch_gate)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // scoreboard queues: which output, expected value, requirement tag
    int    q_sel[$];
    int    q_exp[$];
    string q_tag[$];
    event  chk_ev;

    // reference model
    int mtab[64];
    int mdist = 4;
    int mcnt = 0;
    int mgate = 0;

    always begin
        @(chk_ev);
        while (q_sel.size() > 0) begin
            int s, e, a;
            string t;
            s = q_sel.pop_front();
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            a = (s == 0) ? int'(fetch_conf) : int'(fetch_gate);
            checks++;
            if (a != e) begin
                errors++;
                $display("FAIL %s: %s actual=%0d expected=%0d", t,
                         (s == 0) ? "fetch_conf" : "fetch_gate", a, e);
            end
        end
    end

    task automatic step(bit fv, int fi, bit rv, int ri, bit rok, bit rlow,
                        bit rtk, bit fl, string tag, bit do_chk = 1'b1);
        int hi, conf, sum, c;
        @(negedge clk);
        fetch_vld = fv; fetch_idx = 6'(fi);
        rslv_vld = rv; rslv_idx = 6'(ri); rslv_ok = rok;
        rslv_low = rlow; rslv_taken = rtk; flush = fl;
        #1;
        c = mtab[fi];
        if (cfg_mode) hi = ((c >> 3) & 1) == ((c >> 2) & 1);
        else          hi = (c >= int'(cfg_streak_n));
        conf = (fv && hi && mdist == 4) ? 1 : 0;
        if (do_chk) begin
            q_sel.push_back(0); q_exp.push_back(conf);  q_tag.push_back(tag);
            q_sel.push_back(1); q_exp.push_back(mgate); q_tag.push_back(tag);
            -> chk_ev;
        end
        // next-state of the model for the coming edge
        mgate = (!fl && cfg_thresh != 0 && mcnt >= int'(cfg_thresh)) ? 1 : 0;
        if (fl) mcnt = 0;
        else begin
            sum = mcnt + ((fv && !conf) ? 1 : 0);
            if (rv && rlow && sum > 0) sum--;
            if (sum > 15) sum = 15;
            mcnt = sum;
        end
        if (rv && !rok) mdist = 0;
        else if (fv && mdist < 4) mdist++;
        if (rv) begin
            c = mtab[ri];
            if (cfg_mode) begin
                if (rtk && c < 15) c++;
                else if (!rtk && c > 0) c--;
            end else begin
                c = rok ? ((c < 15) ? c + 1 : 15) : 0;
            end
            mtab[ri] = c;
        end
    endtask

    task automatic fetch(int idx, string tag);
        step(1, idx, 0, 0, 1, 0, 0, 0, tag);
    endtask
    task automatic resolve(int idx, bit ok, bit low, bit tk, string tag);
        step(0, 0, 1, idx, ok, low, tk, 0, tag);
    endtask
    task automatic idle(string tag);
        step(0, 0, 0, 0, 1, 0, 0, 0, tag);
    endtask
    task automatic do_flush(string tag);
        step(0, 0, 0, 0, 1, 0, 0, 1, tag);
    endtask
    task automatic set_cfg(int th, int n, bit m);
        @(negedge clk);
        cfg_thresh = 4'(th); cfg_streak_n = 4'(n); cfg_mode = m;
        step(0, 0, 0, 0, 1, 0, 0, 0, "cfg", 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mtab[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: state after reset
        idle("R1");
        idle("R1");
        // R9: no fetch means no confidence
        idle("R9");

        // R2: streak build-up and clearing
        fetch(7, "R2");                      // entry 0 -> low
        for (int i = 0; i < 3; i++) resolve(7, 1, 1, 0, "R2");
        fetch(7, "R2");                      // streak 3 -> high
        for (int i = 0; i < 20; i++) resolve(7, 1, 0, 0, "R2");
        fetch(7, "R2");
        resolve(7, 0, 0, 0, "R2");           // mispredict clears
        for (int i = 0; i < 4; i++) idle("R2");
        for (int i = 0; i < 4; i++) fetch(9, "R3");
        fetch(7, "R2");                      // cleared entry -> low

        // R3: first four after a mispredict are low
        for (int i = 0; i < 3; i++) resolve(8, 1, 0, 0, "R3");
        resolve(40, 0, 0, 0, "R3");
        for (int i = 0; i < 5; i++) fetch(8, "R3");

        // R8: same-cycle fetch and resolve to the same entry
        step(1, 8, 1, 8, 0, 0, 0, 0, "R8");
        fetch(8, "R8");

        // R4 / R6: count and registered gate
        do_flush("R5");
        fetch(20, "R4");
        fetch(20, "R4");
        idle("R6");
        idle("R6");
        resolve(20, 1, 1, 0, "R4");
        idle("R6");
        idle("R6");
        for (int i = 0; i < 3; i++) resolve(20, 1, 1, 0, "R4");
        fetch(20, "R4");
        idle("R4");
        fetch(20, "R4");
        idle("R6");
        idle("R6");
        // inc and dec together cancel
        step(1, 20, 1, 20, 1, 1, 0, 0, "R4");
        idle("R4");

        // R5: flush clears count and gate
        do_flush("R5");
        idle("R5");
        idle("R5");

        // R6: threshold 0 never gates
        set_cfg(0, 3, 0);
        for (int i = 0; i < 4; i++) fetch(21, "R6");
        idle("R6");
        idle("R6");
        do_flush("R5");

        // R4: saturation at 15
        set_cfg(15, 3, 0);
        for (int i = 0; i < 17; i++) fetch(22, "R4");
        idle("R4");
        idle("R4");
        resolve(22, 1, 1, 0, "R4");
        idle("R4");
        idle("R4");
        do_flush("R5");

        // R7: saturating direction mode
        set_cfg(2, 3, 1);
        fetch(30, "R7");                     // 0 -> high
        for (int i = 0; i < 4; i++) resolve(30, 1, 0, 1, "R7");
        fetch(30, "R7");                     // 4 -> weak, low
        for (int i = 0; i < 8; i++) resolve(30, 1, 0, 1, "R7");
        fetch(30, "R7");                     // 12 -> high
        resolve(30, 1, 0, 0, "R7");
        fetch(30, "R7");                     // 11 -> low
        for (int i = 0; i < 6; i++) resolve(31, 1, 0, 0, "R7");
        fetch(31, "R7");                     // floor at 0 -> high
        resolve(31, 1, 0, 1, "R7");
        for (int i = 0; i < 3; i++) resolve(31, 1, 0, 1, "R7");
        fetch(31, "R7");                     // 4 -> low
        do_flush("R5");
        idle("R9");

        @(negedge clk);
        #1;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule